// File: doc/BRIEF.md
# Fast-Charge Data-Line Negotiation Controller

This controller lets a charging port raise its output voltage after a short exchange with the attached device over the D+ and D− data lines. It does not read the line voltages itself. Per line, it receives three comparator flags: above the data-detect reference (about 0.325 V), above the selection reference (about 2 V), and above the 4 V overvoltage limit. From these flags it drives three things: an enable for the 2.7 V bias on both lines, an enable for the switch that shorts D+ to D−, and a signed code for the feedback current DAC. The code is in steps of 2 µA, with positive values sourcing current. Source 0 gives 5 V, source 20 (40 µA) gives 9 V, source 35 (70 µA) gives 12 V, and sink 7 (code −7, 14 µA) gives 3.6 V.

The controller is a five-state machine.
- **OFF** is the reset state. It is left on the next clock.
- **IDLE** applies the bias and holds the 5 V code. It is entered on `OFF→IDLE`, `SHORT→IDLE` when D+ leaves the window, and `HV/CONT→IDLE` on fallback.
- **SHORT** closes the D+/D− switch and times the qualification. `IDLE→SHORT` fires when D+ enters the window between the two references.
- **HV** applies fixed levels decoded from the filtered line pattern. `SHORT→HV` fires once qualification completes, and `CONT→HV` fires when a fixed pattern settles.
- **CONT** steps the code with qualified pulses. `HV→CONT` fires when the continuous pattern settles.

All times are counts of clock cycles. The defaults assume a 125 kHz clock: 1.25 s for qualification, 40 ms for the selection filter, 150 ms for the continuous-mode filter and 200 µs for a pulse.

Top module: `fchg_dline_ctrl`

## Requirements
- R1: While `rst_n` is low, `short_en` and `bias_en` are 0 and `fb_code` is 0.
- R2: In IDLE (from the second clock after reset, with D+ outside the window), `bias_en`=1, `short_en`=0 and `fb_code`=0. `bias_en` and `short_en` are never 1 together.
- R3: D+ is in the window when `dp_gt_dat`=1 and `dp_gt_sel`=0. While it is in the window, IDLE moves to SHORT on the next clock, with `short_en`=1 and `bias_en`=0.
- R4: SHORT moves to HV (`short_en`=0, `bias_en`=0) only after D+ has stayed in the window for `QUAL_CYC` consecutive cycles. If D+ leaves the window earlier, the block returns to IDLE and the count restarts.
- R5: In HV, the line levels are read as: low = `gt_dat`=0; mid = `gt_dat`=1 and `gt_sel`=0; high = `gt_sel`=1. The patterns decode as follows: D+ mid with D− mid gives code 35; D+ high with D− mid gives code 20; D+ mid with D− low gives code 0.
- R6: A new fixed pattern takes effect only after it has been stable for `VSEL_CYC` cycles. A shorter change leaves `fb_code` unchanged.
- R7: D+ mid with D− high enters CONT only after `CONT_CYC` stable cycles. On entry, `fb_code` keeps its value.
- R8: In CONT, each time D− falls below the selection reference for at least `PULSE_CYC` cycles and then returns high, `fb_code` rises by 1. A shorter low time has no effect.
- R9: Upward stepping saturates at code 35.
- R10: In CONT, each low period of `dec_req_n` of at least `PULSE_CYC` cycles lowers `fb_code` by 1, down to a floor of −7. Outside CONT, such pulses have no effect.
- R11: If `dp_gt_dat` goes to 0 in HV or CONT, the next clock sets `fb_code` to 0 and enters IDLE.
- R12: If either overvoltage flag is 1, the next clock sets `fb_code` to 0 and `short_en` to 0, and detection restarts from IDLE.
- R13: The patterns D+ high with D− high and D+ high with D− low are undefined and keep the current code.
- R14: In CONT, a fixed pattern that stays stable for `VSEL_CYC` cycles loads its code and returns to HV, where stepping stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dp_gt_dat | input | 1 | D+ above the data-detect reference |
| dp_gt_sel | input | 1 | D+ above the selection reference |
| dp_gt_ov | input | 1 | D+ above the overvoltage limit |
| dn_gt_dat | input | 1 | D− above the data-detect reference |
| dn_gt_sel | input | 1 | D− above the selection reference |
| dn_gt_ov | input | 1 | D− above the overvoltage limit |
| dec_req_n | input | 1 | Active-low request to step the code down |
| short_en | output | 1 | Close the D+/D− short switch |
| bias_en | output | 1 | Apply the 2.7 V bias to both lines |
| fb_code | output | CODE_W | Signed feedback current code, 2 µA per step |

## Verification
Every defined pair of line levels, plus both undefined pairs, is applied for longer than the selection filter. This shows that the decoder maps each pair to its own code and that the undefined pairs keep the code. A pair held for less than the filter time checks that short glitches are rejected. D− pulses above and below the qualifying low time separate real steps from noise. The continuous pattern is tried both for longer than the fast filter but shorter than the slow one, and for longer than the slow one; this shows that continuous mode uses its own, longer filter. Long trains of up and down pulses reach both saturation limits. Taking D+ low or raising an overvoltage flag from HV, with a non-zero code, shows the immediate fallback to 5 V.

// File: rtl/fchg_pkg.sv
package fchg_pkg;

    // Controller states
    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_IDLE  = 3'd1,
        ST_SHORT = 3'd2,
        ST_HV    = 3'd3,
        ST_CONT  = 3'd4
    } fchg_state_e;

    // Decoded line-pair selection
    typedef enum logic [2:0] {
        SEL_5V   = 3'd0,
        SEL_9V   = 3'd1,
        SEL_12V  = 3'd2,
        SEL_CONT = 3'd3,
        SEL_HOLD = 3'd4
    } fchg_sel_e;

endpackage

// File: rtl/fchg_debounce.sv
module fchg_debounce
    import fchg_pkg::*;
#(
    parameter int FAST_CYC = 12,
    parameter int SLOW_CYC = 24,
    parameter int CNT_W    = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  fchg_sel_e raw,
    output fchg_sel_e stable
);
    localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_CYC - 1);
    localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_CYC - 1);

    fchg_sel_e        cand;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // the continuous pattern uses the longer filter
    assign last = (cand == SEL_CONT) ? SLOW_LAST : FAST_LAST;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cand   <= SEL_5V;
            stable <= SEL_5V;
            cnt    <= '0;
        end else if (raw != cand) begin
            cand <= raw;
            cnt  <= '0;
        end else if (cnt >= last) begin
            stable <= cand;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fchg_pulse_qual.sv
module fchg_pulse_qual #(
    parameter int MIN_LOW = 25,
    parameter int CNT_W   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic lvl_low,
    output logic step
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(MIN_LOW);

    logic [CNT_W-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            low_cnt <= '0;
            step    <= 1'b0;
        end else begin
            step <= 1'b0;
            if (lvl_low) begin
                if (low_cnt < LIM) low_cnt <= low_cnt + 1'b1;
            end else begin
                step    <= (low_cnt == LIM);
                low_cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/fchg_code_step.sv
module fchg_code_step #(
    parameter int CODE_W = 7,
    parameter int MAX_V  = 35,
    parameter int MIN_V  = -7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic signed [CODE_W-1:0] load_val,
    input  logic                     inc,
    input  logic                     dec,
    output logic signed [CODE_W-1:0] code
);
    localparam logic signed [CODE_W-1:0] TOP = CODE_W'(MAX_V);
    localparam logic signed [CODE_W-1:0] BOT = CODE_W'(MIN_V);
    localparam logic signed [CODE_W-1:0] ONE = CODE_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
        end else if (load) begin
            code <= load_val;
        end else if (inc && !dec && (code < TOP)) begin
            code <= code + ONE;
        end else if (dec && !inc && (code > BOT)) begin
            code <= code - ONE;
        end
    end

endmodule

// File: rtl/fchg_dline_ctrl.sv
module fchg_dline_ctrl
    import fchg_pkg::*;
#(
    parameter int QUAL_CYC  = 156250,
    parameter int VSEL_CYC  = 5000,
    parameter int CONT_CYC  = 18750,
    parameter int PULSE_CYC = 25,
    parameter int CODE_W    = 7,
    parameter int CODE_9V   = 20,
    parameter int CODE_12V  = 35,
    parameter int CODE_MIN  = -7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     dp_gt_dat,
    input  logic                     dp_gt_sel,
    input  logic                     dp_gt_ov,
    input  logic                     dn_gt_dat,
    input  logic                     dn_gt_sel,
    input  logic                     dn_gt_ov,
    input  logic                     dec_req_n,
    output logic                     short_en,
    output logic                     bias_en,
    output logic signed [CODE_W-1:0] fb_code
);
    localparam int QUAL_W  = $clog2(QUAL_CYC + 1);
    localparam int FILT_MX = (CONT_CYC > VSEL_CYC) ? CONT_CYC : VSEL_CYC;
    localparam int FILT_W  = $clog2(FILT_MX + 1);
    localparam int PULS_W  = $clog2(PULSE_CYC + 1);
    localparam logic [QUAL_W-1:0]        QUAL_LAST = QUAL_W'(QUAL_CYC - 1);
    localparam logic signed [CODE_W-1:0] C5  = '0;
    localparam logic signed [CODE_W-1:0] C9  = CODE_W'(CODE_9V);
    localparam logic signed [CODE_W-1:0] C12 = CODE_W'(CODE_12V);

    fchg_state_e       state, state_nx;
    fchg_sel_e         sel_raw, sel_q;
    logic [QUAL_W-1:0] qual_cnt;
    logic              dp_win, dp_gone, ov_any;
    logic              dn_low, dn_mid;
    logic              load;
    logic signed [CODE_W-1:0] load_val;
    logic              step_en;
    logic [1:0]        lvl_low;
    logic [1:0]        step;

    assign dp_win  = dp_gt_dat && !dp_gt_sel;
    assign dp_gone = !dp_gt_dat;
    assign ov_any  = dp_gt_ov || dn_gt_ov;
    assign dn_low  = !dn_gt_dat;
    assign dn_mid  = dn_gt_dat && !dn_gt_sel;

    // line-pair decode
    always_comb begin
        if (dp_win && dn_mid)            sel_raw = SEL_12V;
        else if (dp_gt_sel && dn_mid)    sel_raw = SEL_9V;
        else if (dp_win && dn_gt_sel)    sel_raw = SEL_CONT;
        else if (dp_win && dn_low)       sel_raw = SEL_5V;
        else                             sel_raw = SEL_HOLD;
    end

    fchg_debounce #(
        .FAST_CYC (VSEL_CYC),
        .SLOW_CYC (CONT_CYC),
        .CNT_W    (FILT_W)
    ) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!(state == ST_HV || state == ST_CONT)),
        .raw    (sel_raw),
        .stable (sel_q)
    );

    // index 0: D- up pulses, index 1: down requests
    assign lvl_low[0] = !dn_gt_sel;
    assign lvl_low[1] = !dec_req_n;

    for (genvar gi = 0; gi < 2; gi++) begin : g_pq
        fchg_pulse_qual #(
            .MIN_LOW (PULSE_CYC),
            .CNT_W   (PULS_W)
        ) u_pq (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (step_en),
            .lvl_low (lvl_low[gi]),
            .step    (step[gi])
        );
    end

    fchg_code_step #(
        .CODE_W (CODE_W),
        .MAX_V  (CODE_12V),
        .MIN_V  (CODE_MIN)
    ) u_code (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .inc      (step[0]),
        .dec      (step[1]),
        .code     (fb_code)
    );

    // qualification timer, runs only in SHORT
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_SHORT) qual_cnt <= '0;
        else if (qual_cnt < QUAL_LAST)   qual_cnt <= qual_cnt + 1'b1;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:   state_nx = ST_IDLE;
            ST_IDLE:  if (!ov_any && dp_win) state_nx = ST_SHORT;
            ST_SHORT: begin
                if (ov_any || !dp_win)          state_nx = ST_IDLE;
                else if (qual_cnt == QUAL_LAST) state_nx = ST_HV;
            end
            ST_HV: begin
                if (ov_any || dp_gone)      state_nx = ST_IDLE;
                else if (sel_q == SEL_CONT) state_nx = ST_CONT;
            end
            ST_CONT: begin
                if (ov_any || dp_gone) state_nx = ST_IDLE;
                else if (sel_q == SEL_5V || sel_q == SEL_9V || sel_q == SEL_12V)
                    state_nx = ST_HV;
            end
            default:  state_nx = ST_OFF;
        endcase
    end

    // outputs and code control
    always_comb begin
        short_en = 1'b0;
        bias_en  = 1'b0;
        step_en  = 1'b0;
        load     = 1'b0;
        load_val = C5;
        unique case (state)
            ST_OFF:   ;
            ST_IDLE:  bias_en  = 1'b1;
            ST_SHORT: short_en = 1'b1;
            ST_HV, ST_CONT: begin
                step_en = (state == ST_CONT);
                if (ov_any || dp_gone) begin
                    load = 1'b1;
                end else begin
                    unique case (sel_q)
                        SEL_5V:  load = 1'b1;
                        SEL_9V:  begin load = 1'b1; load_val = C9;  end
                        SEL_12V: begin load = 1'b1; load_val = C12; end
                        default: ;
                    endcase
                end
            end
            default:  ;
        endcase
    end

endmodule

// File: rtl/fchg_dline_chk.sv
module fchg_dline_chk #(
    parameter int CODE_W   = 7,
    parameter int CODE_12V = 35,
    parameter int CODE_MIN = -7
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     dp_gt_dat,
    input logic                     dp_gt_sel,
    input logic                     dp_gt_ov,
    input logic                     dn_gt_ov,
    input logic                     short_en,
    input logic                     bias_en,
    input logic signed [CODE_W-1:0] fb_code
);
    localparam logic signed [CODE_W-1:0] TOP = CODE_W'(CODE_12V);
    localparam logic signed [CODE_W-1:0] BOT = CODE_W'(CODE_MIN);

    // R1
    reset_out_chk: assert property (@(posedge clk)
        !rst_n |=> (!short_en && !bias_en && fb_code == '0));

    // R2
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(short_en && bias_en));

    // R3
    short_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(short_en) |-> $past(dp_gt_dat && !dp_gt_sel));

    // R9
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_code <= TOP) && (fb_code >= BOT));

    // R11
    dp_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dp_gt_dat |=> (fb_code == '0));

    // R12
    ov_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_gt_ov || dn_gt_ov) |=> (fb_code == '0 && !short_en));

endmodule

bind fchg_dline_ctrl fchg_dline_chk #(
    .CODE_W   (CODE_W),
    .CODE_12V (CODE_12V),
    .CODE_MIN (CODE_MIN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dp_gt_dat (dp_gt_dat),
    .dp_gt_sel (dp_gt_sel),
    .dp_gt_ov  (dp_gt_ov),
    .dn_gt_ov  (dn_gt_ov),
    .short_en  (short_en),
    .bias_en   (bias_en),
    .fb_code   (fb_code)
);

// File: tb/tb_fchg_dline_ctrl.sv
`timescale 1ns/1ps
module tb_fchg_dline_ctrl;
    localparam int QUAL  = 40;
    localparam int VSEL  = 12;
    localparam int CONT  = 24;
    localparam int PULSE = 5;
    localparam int CW    = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] dp_lvl = 2'd0, dn_lvl = 2'd0;   // 0 low, 1 mid, 2 high
    logic dp_ov = 1'b0, dn_ov = 1'b0, dec_n = 1'b1;
    logic short_en, bias_en;
    logic signed [CW-1:0] fb_code;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fchg_dline_ctrl #(
        .QUAL_CYC (QUAL), .VSEL_CYC (VSEL), .CONT_CYC (CONT), .PULSE_CYC (PULSE),
        .CODE_W (CW), .CODE_9V (20), .CODE_12V (35), .CODE_MIN (-7)
    ) dut (
        .clk (clk), .rst_n (rst_n),
        .dp_gt_dat (dp_lvl >= 2'd1), .dp_gt_sel (dp_lvl == 2'd2), .dp_gt_ov (dp_ov),
        .dn_gt_dat (dn_lvl >= 2'd1), .dn_gt_sel (dn_lvl == 2'd2), .dn_gt_ov (dn_ov),
        .dec_req_n (dec_n),
        .short_en (short_en), .bias_en (bias_en), .fb_code (fb_code)
    );

    // {dp, dn, hold cycles, expected code, requirement}
    localparam int NV = 8;
    localparam logic [23:0] VECS [NV] = '{
        {2'd1, 2'd1, 8'd30, 8'sd35, 4'd5},   // R5 12V pair
        {2'd2, 2'd1, 8'd30, 8'sd20, 4'd5},   // R5 9V pair
        {2'd1, 2'd0, 8'd30, 8'sd0,  4'd5},   // R5 5V pair
        {2'd2, 2'd1, 8'd5,  8'sd0,  4'd6},   // R6 short change ignored
        {2'd1, 2'd1, 8'd30, 8'sd35, 4'd6},   // R6 stable change applied
        {2'd2, 2'd2, 8'd30, 8'sd35, 4'd13},  // R13 undefined pair
        {2'd2, 2'd0, 8'd30, 8'sd35, 4'd13},  // R13 undefined pair
        {2'd1, 2'd0, 8'd30, 8'sd0,  4'd5}    // R5 back to 5V
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_lines(input logic [1:0] p, input logic [1:0] n);
        dp_lvl = p;
        dn_lvl = n;
    endtask

    task automatic go_hv();
        set_lines(2'd0, 2'd0);
        tick(3);
        set_lines(2'd1, 2'd0);
        tick(QUAL + 15);
    endtask

    task automatic up_pulse(input int low_len);
        dn_lvl = 2'd1;
        tick(low_len);
        dn_lvl = 2'd2;
        tick(4);
    endtask

    task automatic down_pulse(input int low_len);
        dec_n = 1'b0;
        tick(low_len);
        dec_n = 1'b1;
        tick(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        // R1 reset state
        check("R1 short", int'(short_en), 0);
        check("R1 bias", int'(bias_en), 0);
        check("R1 code", int'(fb_code), 0);
        rst_n = 1'b1;
        tick(2);
        // R2 idle biases the lines
        check("R2 bias", int'(bias_en), 1);
        check("R2 short", int'(short_en), 0);

        // R3 window closes the short
        set_lines(2'd1, 2'd0);
        tick(2);
        check("R3 short", int'(short_en), 1);
        check("R3 bias", int'(bias_en), 0);
        // R4 early exit restarts detection
        tick(20);
        check("R4 still short", int'(short_en), 1);
        dp_lvl = 2'd0;
        tick(2);
        check("R4 restart bias", int'(bias_en), 1);
        dp_lvl = 2'd1;
        tick(QUAL - 5);
        check("R4 not yet HV", int'(short_en), 1);
        tick(20);
        check("R4 HV short", int'(short_en), 0);
        check("R4 HV bias", int'(bias_en), 0);

        // table walk in HV
        for (int i = 0; i < NV; i++) begin
            set_lines(VECS[i][23:22], VECS[i][21:20]);
            tick(int'(VECS[i][19:12]));
            check($sformatf("R%0d vec%0d", VECS[i][3:0], i),
                  int'(fb_code), int'($signed(VECS[i][11:4])));
        end

        // R11 D+ removed falls back to 5V
        set_lines(2'd1, 2'd1);
        tick(30);
        check("R11 pre", int'(fb_code), 35);
        dp_lvl = 2'd0;
        tick(2);
        check("R11 code", int'(fb_code), 0);
        check("R11 bias", int'(bias_en), 1);

        // R12 overvoltage on D-
        go_hv();
        set_lines(2'd2, 2'd1);
        tick(30);
        check("R12 pre", int'(fb_code), 20);
        dn_ov = 1'b1;
        tick(1);
        dn_ov = 1'b0;
        check("R12 code", int'(fb_code), 0);
        check("R12 bias", int'(bias_en), 1);

        // continuous mode
        go_hv();
        set_lines(2'd2, 2'd1);
        tick(30);
        set_lines(2'd1, 2'd2);
        tick(16);                  // past VSEL but short of CONT
        up_pulse(8);
        check("R7 not entered early", int'(fb_code), 20);
        tick(40);
        check("R7 entry keeps code", int'(fb_code), 20);
        up_pulse(8);
        check("R8 step up", int'(fb_code), 21);
        up_pulse(3);
        check("R8 short pulse", int'(fb_code), 21);
        for (int k = 0; k < 20; k++) up_pulse(8);
        check("R9 cap", int'(fb_code), 35);
        for (int k = 0; k < 3; k++) down_pulse(8);
        check("R10 step down", int'(fb_code), 32);
        for (int k = 0; k < 50; k++) down_pulse(8);
        check("R10 floor", int'(fb_code), -7);

        // R14 fixed pattern leaves continuous mode
        set_lines(2'd2, 2'd1);
        tick(30);
        check("R14 load", int'(fb_code), 20);
        down_pulse(8);
        check("R14 no stepping", int'(fb_code), 20);
        check("R10 ignored in HV", int'(fb_code), 20);

        // R12 overvoltage on D+
        dp_ov = 1'b1;
        tick(1);
        dp_ov = 1'b0;
        check("R12 dp code", int'(fb_code), 0);
        check("R12 dp short", int'(short_en), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule